// File: doc/BRIEF.md
# Oversampling UART Receiver with Address Filter

This block turns an asynchronous serial line into received characters. It looks at the incoming line once per pulse of a 16x-bit-rate enable. It finds the start of a frame on a falling edge. It decides every bit from three samples around the middle of the bit period, so a short noise spike does not change the result. Five frame formats are selected by a 3-bit format code. Parity and the first stop bit are checked. The finished character goes into a holding buffer, so the next frame can arrive while software still owns the previous one.

In the address-filter format only frames whose ninth bit is 1 reach the buffer. A node on a shared line can therefore ignore data meant for other nodes. A loop-back select takes the local transmitter's serial output in place of the external pin. Baud generation and register decoding are done elsewhere. The block receives a ready-made oversampling enable and a one-cycle read strobe.

Top module: `rxw_uart_rx`

## Requirements
- R1: A frame starts only on a high-to-low change of the sampled line while `run_en` and `rx_en` are both 1. With either of them at 0, a full frame on the line produces no `rx_irq` and leaves `rx_buf` unchanged.
- R2: Each bit is the majority of oversample ticks 7, 8 and 9 of its 16-tick period. The tick on which the falling edge is seen is tick 1 of the start bit. A bit whose ticks 7 and 9 are correct is received correctly even when every other tick, including tick 8, is inverted.
- R3: Format codes on `fmt`:
  - 3'b001: eight data bits.
  - 3'b011: seven data bits plus parity.
  - 3'b100: nine data bits.
  - 3'b101: eight data bits plus address bit.
  - 3'b111: eight data bits plus parity.
  - Any other code is received as 3'b001.
  Received bits are stored LSB first from `rx_buf[0]`. In the eight-bit formats `rx_buf[15:8]` is 0, and in the nine-bit formats `rx_buf[15:9]` is 0.
- R4: Parity is checked only in formats 3'b011 and 3'b111. The even parity bit equals the XOR of the data bits, and `odd_par`=1 inverts it. `par_err` is 1 when the received parity bit differs from the expected one. In all other formats `par_err` stays 0.
- R5: The received parity bit is held at `rx_buf[7]` in format 3'b011 and at `rx_buf[8]` in format 3'b111.
- R6: In format 3'b101 a frame whose ninth bit is 0 is discarded. It causes no `rx_irq` and no `err_irq`, and leaves `rx_buf` and all error flags unchanged. A frame whose ninth bit is 1 is accepted with that bit at `rx_buf[8]`.
- R7: A frame whose first stop bit is sampled as 0 sets `frm_err`. The character is still stored.
- R8: If a frame is accepted while the previous character is unread and no `rd_ack` arrives in the same cycle, `ovr_err` is set and the new character replaces the old one. `rd_ack` marks the buffer read and clears all three error flags.
- R9: A new frame can be received while a character is held. An `rd_ack` during the new frame avoids an overrun.
- R10: With `loopback`=1 the receiver takes `tx_loop` and ignores `rx_pin`. With `loopback`=0 it takes `rx_pin` and ignores `tx_loop`.
- R11: If the start bit's vote is 1, the event is treated as a glitch. The receiver returns to idle and accepts no frame.
- R12: Each accepted frame gives exactly one one-cycle `rx_irq` pulse. `err_irq` pulses in the same cycle when that frame sets a parity, framing or overrun error. The error flags describe the character in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| run_en | input | 1 | Bit-rate generator running |
| rx_en | input | 1 | Receiver enable |
| fmt | input | 3 | Frame format code (R3) |
| odd_par | input | 1 | 1 selects odd parity |
| loopback | input | 1 | 1 receives from `tx_loop` |
| rx_pin | input | 1 | External serial input |
| tx_loop | input | 1 | Local transmitter serial output |
| rd_ack | input | 1 | One-cycle strobe: buffer has been read |
| rx_buf | output | 16 | Received character, zero-extended |
| rx_irq | output | 1 | Pulse per accepted frame |
| err_irq | output | 1 | Pulse when an accepted frame has an error |
| par_err | output | 1 | Parity error of the held character |
| frm_err | output | 1 | Stop-bit error of the held character |
| ovr_err | output | 1 | Held character overwrote an unread one |

## Verification
All 256 eight-bit values, a stride through the nine-bit space, and both parity senses with good and bad parity are swept, and the buffer and flags are predicted by arithmetic.

Specific corner cases target common wrong designs:
- Frames where only ticks 7 and 9 carry the right value catch a design that votes on the wrong ticks or takes a single sample.
- Short low pulses, one ending before tick 7 and one holding only tick 7 low, catch a design that starts on an edge without confirming the start bit.
- Address-filter frames with the ninth bit at 0 expose a design that still raises an interrupt or overwrites the buffer.
- Back-to-back frames with and without a read in between separate correct overrun flagging from a design that loses the new character or flags an overrun after a read.
- Frames sent on the non-selected loop-back input check that it is ignored.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   localparam logic [2:0] FMT_D8  = 3'b001;
   localparam logic [2:0] FMT_D7P = 3'b011;
   localparam logic [2:0] FMT_D9  = 3'b100;
   localparam logic [2:0] FMT_D8W = 3'b101;
   localparam logic [2:0] FMT_D8P = 3'b111;

   function automatic logic fmt_nine(input logic [2:0] f);
      return (f == FMT_D9) || (f == FMT_D8W) || (f == FMT_D8P);
   endfunction

   function automatic logic fmt_par(input logic [2:0] f);
      return (f == FMT_D7P) || (f == FMT_D8P);
   endfunction

   function automatic logic fmt_wake(input logic [2:0] f);
      return f == FMT_D8W;
   endfunction

endpackage

// File: rtl/rxw_sync.sv
module rxw_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("rxw_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{INIT}};
         else        chain <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{INIT}};
         else        chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rxw_frame.sv
module rxw_frame #(
   parameter int OVS      = 16,
   parameter int DATA_MAX = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                enable,
   input  logic                line,
   input  logic                nine,
   output logic                done,
   output logic                stop_bad,
   output logic [DATA_MAX-1:0] data
);

   localparam int CW     = $clog2(OVS);
   localparam int BW     = $clog2(DATA_MAX + 2);
   localparam int VOTE_A = OVS / 2 - 2;
   localparam int VOTE_B = OVS / 2 - 1;
   localparam int VOTE_C = OVS / 2;

   if (OVS < 8 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("rxw_frame: OVS must be even and at least 8");
   end
   if (DATA_MAX < 2) begin : g_bad_data
      $error("rxw_frame: DATA_MAX must be at least 2");
   end

   typedef enum logic {S_IDLE, S_RUN} st_t;

   st_t           st;
   logic          prev;
   logic [CW-1:0] cnt;
   logic [CW-1:0] idx_nx;
   logic [BW-1:0] bitn;
   logic [BW-1:0] nbits;
   logic          s_a, s_b, maj;

   always_comb begin
      idx_nx = (cnt == CW'(OVS - 1)) ? '0 : cnt + CW'(1);
      maj    = (s_a & s_b) | (s_a & line) | (s_b & line);
      nbits  = nine ? BW'(DATA_MAX) : BW'(DATA_MAX - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         prev     <= 1'b1;
         cnt      <= '0;
         bitn     <= '0;
         s_a      <= 1'b0;
         s_b      <= 1'b0;
         done     <= 1'b0;
         stop_bad <= 1'b0;
         data     <= '0;
      end else begin
         done <= 1'b0;
         if (tick) prev <= line;
         if (!enable) begin
            st <= S_IDLE;
         end else if (tick) begin
            case (st)
               S_IDLE: begin
                  if (prev && !line) begin
                     st   <= S_RUN;
                     cnt  <= '0;
                     bitn <= '0;
                     data <= '0;
                  end
               end
               S_RUN: begin
                  cnt <= idx_nx;
                  if (cnt == CW'(OVS - 1)) bitn <= bitn + BW'(1);
                  if (idx_nx == CW'(VOTE_A)) s_a <= line;
                  if (idx_nx == CW'(VOTE_B)) s_b <= line;
                  if (idx_nx == CW'(VOTE_C)) begin
                     if (bitn == '0) begin
                        if (maj) st <= S_IDLE;
                     end else if (bitn <= nbits) begin
                        data[bitn - BW'(1)] <= maj;
                     end else begin
                        done     <= 1'b1;
                        stop_bad <= !maj;
                        st       <= S_IDLE;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && !enable) |=> (st == S_IDLE));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/rxw_store.sv
module rxw_store #(
   parameter int DATA_MAX = 9,
   parameter int BUF_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic                stop_bad,
   input  logic [DATA_MAX-1:0] data,
   input  logic [2:0]          fmt,
   input  logic                odd_par,
   input  logic                rd_ack,
   output logic [BUF_W-1:0]    rx_buf,
   output logic                rx_irq,
   output logic                err_irq,
   output logic                par_err,
   output logic                frm_err,
   output logic                ovr_err
);
   import rxw_pkg::*;

   if (BUF_W < DATA_MAX) begin : g_bad_buf
      $error("rxw_store: BUF_W must hold DATA_MAX bits");
   end

   logic full;
   logic accept, pe, ov;

   always_comb begin
      accept = done && !(fmt_wake(fmt) && !data[DATA_MAX-1]);
      pe     = fmt_par(fmt) && ((^data) != odd_par);
      ov     = full && !rd_ack;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         full    <= 1'b0;
         rx_irq  <= 1'b0;
         err_irq <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
         ovr_err <= 1'b0;
      end else begin
         rx_irq  <= accept;
         err_irq <= accept && (pe || stop_bad || ov);
         if (accept) begin
            rx_buf  <= BUF_W'(data);
            full    <= 1'b1;
            par_err <= pe;
            frm_err <= stop_bad;
            ovr_err <= ov;
         end else if (rd_ack) begin
            full    <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
            ovr_err <= 1'b0;
         end
      end
   end

   // R6
   wake_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && fmt_wake($past(fmt))) |-> rx_buf[DATA_MAX-1]);

   // R3
   eight_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !fmt_nine($past(fmt))) |-> !rx_buf[DATA_MAX-1]);

   // R4
   no_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq && !fmt_par($past(fmt))) |-> !par_err);

   // R8
   ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> rx_irq);

   // R7
   frm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frm_err) |-> rx_irq);

   // R12
   err_with_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> (rx_irq && (par_err || frm_err || ovr_err)));

endmodule

// File: rtl/rxw_uart_rx.sv
module rxw_uart_rx #(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_MAX    = 9,
   parameter int BUF_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick16,
   input  logic             run_en,
   input  logic             rx_en,
   input  logic [2:0]       fmt,
   input  logic             odd_par,
   input  logic             loopback,
   input  logic             rx_pin,
   input  logic             tx_loop,
   input  logic             rd_ack,
   output logic [BUF_W-1:0] rx_buf,
   output logic             rx_irq,
   output logic             err_irq,
   output logic             par_err,
   output logic             frm_err,
   output logic             ovr_err
);
   import rxw_pkg::*;

   logic                src, line_s, done, stop_bad;
   logic [DATA_MAX-1:0] data;

   assign src = loopback ? tx_loop : rx_pin;

   rxw_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src), .q(line_s)
   );

   rxw_frame #(.OVS(OVS), .DATA_MAX(DATA_MAX)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick16),
      .enable(run_en && rx_en), .line(line_s), .nine(fmt_nine(fmt)),
      .done(done), .stop_bad(stop_bad), .data(data)
   );

   rxw_store #(.DATA_MAX(DATA_MAX), .BUF_W(BUF_W)) u_store (
      .clk(clk), .rst_n(rst_n), .done(done), .stop_bad(stop_bad),
      .data(data), .fmt(fmt), .odd_par(odd_par), .rd_ack(rd_ack),
      .rx_buf(rx_buf), .rx_irq(rx_irq), .err_irq(err_irq),
      .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
   );

endmodule

// File: tb/sim_rxw_uart_rx.sv
module sim_rxw_uart_rx;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick16 = 1'b0, run_en = 1'b1, rx_en = 1'b1;
   logic [2:0]  fmt = 3'b001;
   logic        odd_par = 1'b0, loopback = 1'b0;
   logic        rx_pin = 1'b1, tx_loop = 1'b1, rd_ack = 1'b0;
   logic [15:0] rx_buf;
   logic        rx_irq, err_irq, par_err, frm_err, ovr_err;

   int  compared = 0, mismatched = 0;
   int  irq_cnt = 0, err_cnt = 0, irq0 = 0, err0 = 0;
   int  div = 1;
   bit  via_loop = 0;
   bit  finished = 0;
   logic [15:0] last_buf = '0;
   logic        lp = 0, lf = 0, lo = 0;

   rxw_uart_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .run_en(run_en),
      .rx_en(rx_en), .fmt(fmt), .odd_par(odd_par), .loopback(loopback),
      .rx_pin(rx_pin), .tx_loop(tx_loop), .rd_ack(rd_ack),
      .rx_buf(rx_buf), .rx_irq(rx_irq), .err_irq(err_irq),
      .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (rx_irq)  irq_cnt <= irq_cnt + 1;
      if (err_irq) err_cnt <= err_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic slot(input logic v, input bit ack);
      @(negedge clk);
      if (via_loop) tx_loop = v; else rx_pin = v;
      tick16 = 1'b1;
      rd_ack = ack;
      for (int i = 1; i < div; i++) begin
         @(negedge clk);
         tick16 = 1'b0;
         rd_ack = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(1'b1, 1'b0);
   endtask

   task automatic send(input logic [8:0] p, input int nb, input logic stopv,
                       input bit corrupt, input int ack_slot);
      int s = 0;
      for (int b = 0; b <= nb + 1; b++) begin
         logic v;
         v = (b == 0) ? 1'b0 : (b <= nb) ? p[b-1] : stopv;
         for (int k = 1; k <= 16; k++) begin
            logic w;
            w = (corrupt && b >= 1 && b <= nb && k != 7 && k != 9) ? ~v : v;
            slot(w, s == ack_slot);
            s++;
         end
      end
   endtask

   task automatic do_read;
      @(negedge clk);
      tick16 = 1'b0;
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      lp = 0; lf = 0; lo = 0;
   endtask

   task automatic mark;
      irq0 = irq_cnt;
      err0 = err_cnt;
   endtask

   task automatic expect_state(input string tag, input logic [15:0] eb,
                               input logic ep, input logic ef, input logic eo,
                               input int di, input int de);
      logic [31:0] got, exp;
      @(negedge clk);
      got = {5'd0, rx_buf, par_err, frm_err, ovr_err, 4'(irq_cnt - irq0), 4'(err_cnt - err0)};
      exp = {5'd0, eb, ep, ef, eo, 4'(di), 4'(de)};
      chk(tag, got, exp);
   endtask

   task automatic frame(input string tag, input logic [2:0] f, input logic [8:0] p,
                        input logic stopv, input bit corrupt, input int ack_slot,
                        input bit acc, input logic ep, input logic ef, input logic eo,
                        input bit rd);
      bit nine;
      int nb;
      logic [15:0] eb;
      nine = (f == 3'b100) || (f == 3'b101) || (f == 3'b111);
      nb = nine ? 9 : 8;
      fmt = f;
      mark();
      send(p, nb, stopv, corrupt, ack_slot);
      idle(4);
      if (acc) begin
         eb = nine ? {7'd0, p} : {8'd0, p[7:0]};
         last_buf = eb;
         lp = ep; lf = ef; lo = eo;
         expect_state(tag, eb, ep, ef, eo, 1, (ep | ef | eo) ? 1 : 0);
      end else begin
         expect_state(tag, last_buf, lp, lf, lo, 0, 0);
      end
      if (rd) do_read();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      mark();
      expect_state("reset", 16'h0000, 0, 0, 0, 0, 0);
      idle(4);

      // R1: disabled receiver or stopped rate generator ignores frames
      rx_en = 1'b0;
      frame("R1 rx_en low", 3'b001, 9'h0A5, 1'b1, 0, -1, 0, 0, 0, 0, 0);
      rx_en = 1'b1; run_en = 1'b0;
      frame("R1 run_en low", 3'b001, 9'h03C, 1'b1, 0, -1, 0, 0, 0, 0, 0);
      run_en = 1'b1;
      idle(4);

      // R11: short low pulses are glitches
      mark();
      for (int i = 0; i < 5; i++) slot(1'b0, 1'b0);
      idle(200);
      expect_state("R11 short pulse", last_buf, lp, lf, lo, 0, 0);
      mark();
      for (int i = 0; i < 7; i++) slot(1'b0, 1'b0);
      idle(200);
      expect_state("R11 vote tick7 only", last_buf, lp, lf, lo, 0, 0);

      // R2: only ticks 7 and 9 of each data bit carry the real value
      frame("R2 vote 8bit", 3'b001, 9'h0B4, 1'b1, 1, -1, 1, 0, 0, 0, 1);
      frame("R2 vote 9bit", 3'b100, 9'h14B, 1'b1, 1, -1, 1, 0, 0, 0, 1);

      // R3: all eight-bit values
      for (int v = 0; v < 256; v++)
         frame("R3 sweep 8bit", 3'b001, 9'(v), 1'b1, 0, -1, 1, 0, 0, 0, 1);
      // R3: undefined code behaves as eight-bit
      frame("R3 code 010", 3'b010, 9'h0C3, 1'b1, 0, -1, 1, 0, 0, 0, 1);
      // R3 and R4: nine-bit values, parity never flagged
      for (int v = 0; v < 512; v += 5)
         frame("R3 R4 sweep 9bit", 3'b100, 9'(v), 1'b1, 0, -1, 1, 0, 0, 0, 1);

      // R4 and R5: parity formats, both senses, good and bad parity bit
      for (int o = 0; o < 2; o++) begin
         odd_par = o[0];
         for (int i = 0; i < 32; i++) begin
            for (int bad = 0; bad < 2; bad++) begin
               logic [6:0] d7;
               logic [7:0] d8;
               logic pb;
               d7 = 7'(i * 4 + 1);
               pb = (^d7) ^ o[0] ^ bad[0];
               frame("R4 R5 7+par", 3'b011, {1'b0, pb, d7}, 1'b1, 0, -1, 1, bad[0], 0, 0, 1);
               d8 = 8'(i * 8 + 3);
               pb = (^d8) ^ o[0] ^ bad[0];
               frame("R4 R5 8+par", 3'b111, {pb, d8}, 1'b1, 0, -1, 1, bad[0], 0, 0, 1);
            end
         end
      end
      odd_par = 1'b0;

      // R6: address filter
      frame("R6 address accepted", 3'b101, 9'h1A5, 1'b1, 0, -1, 1, 0, 0, 0, 1);
      frame("R6 data dropped", 3'b101, 9'h055, 1'b1, 0, -1, 0, 0, 0, 0, 0);
      frame("R6 bad stop dropped", 3'b101, 9'h077, 1'b0, 0, -1, 0, 0, 0, 0, 0);
      idle(20);

      // R7: framing error, character kept
      frame("R7 stop low", 3'b001, 9'h05A, 1'b0, 0, -1, 1, 0, 1, 0, 0);
      do_read();
      idle(20);

      // R8: overrun replaces old character; read clears flags
      frame("R8 first", 3'b001, 9'h011, 1'b1, 0, -1, 1, 0, 0, 0, 0);
      frame("R8 overrun", 3'b001, 9'h022, 1'b1, 0, -1, 1, 0, 0, 1, 0);
      do_read();
      mark();
      expect_state("R8 flags cleared", 16'h0022, 0, 0, 0, 0, 0);

      // R9: read during the next frame avoids overrun
      frame("R9 held", 3'b100, 9'h133, 1'b1, 0, -1, 1, 0, 0, 0, 0);
      frame("R9 read mid-frame", 3'b100, 9'h0CC, 1'b1, 0, 40, 1, 0, 0, 0, 1);

      // R10: loop-back source selection
      rx_pin = 1'b0;
      loopback = 1'b1;
      via_loop = 1;
      idle(4);
      frame("R10 loop path", 3'b001, 9'h069, 1'b1, 0, -1, 1, 0, 0, 0, 1);
      rx_pin = 1'b1;
      idle(2);
      loopback = 1'b0;
      idle(4);
      frame("R10 loop ignored", 3'b001, 9'h096, 1'b1, 0, -1, 0, 0, 0, 0, 0);
      via_loop = 0;
      idle(4);

      // R2 R12: slower tick rate
      div = 3;
      idle(4);
      frame("R12 slow tick a", 3'b001, 9'h0E1, 1'b1, 0, -1, 1, 0, 0, 0, 1);
      frame("R12 slow tick b", 3'b111, 9'h1F0, 1'b1, 0, -1, 1, 1, 0, 0, 1);
      frame("R2 slow tick vote", 3'b100, 9'h0F5, 1'b1, 1, -1, 1, 0, 0, 0, 1);
      div = 1;

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule